// File: doc/BRIEF.md
# External Memory Bus Sequencer with Wait-State Control

This block runs read and write cycles on an external memory bus for a small controller core. The core hands over one request at a time: an address, write data, a direction and a chip-select index. The block then drives the address lines, the shared address/data (AD) lines, the active-low read and write strobes and one active-low chip select. A read returns the sampled bus data to the core with a one-cycle response pulse. One clock period of the block is one bus state time.

Each chip-select region has its own settings. One flag picks the multiplexed mode, where the AD lines carry the low address bits in a first address state and then carry data. Without that flag the region uses demultiplexed mode, where the address stays on its own lines for the whole cycle and the strobe window is one state longer. A 2-bit field for each region sets 0 to 3 internal wait states. A low READY input from the addressed device adds further states once the internal waits have run out.

Right after reset a fixed boot rule applies. The first completed cycle always uses three internal waits. The second completed cycle uses a wait count taken from the data seen on the bus during the first cycle. The per-region fields take over only from the third cycle on.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and the core must hold its request fields steady until the acceptance edge. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the core must take `rsp_rdata` in that cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no cycle is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance until the cycle in which `rsp_valid` rises, and it is low in that cycle.
- R2: Demultiplexed region (`cfg_muxed[cs]` = 0). `bus_addr` equals the request address in every busy cycle. The strobe is low for 2+W cycles and `busy` lasts 3+W cycles, where W is the total number of wait states.
- R3: Multiplexed region (`cfg_muxed[cs]` = 1). The first busy cycle has `bus_ale` high, `bus_ad_oe` high, `bus_ad_out` equal to the address bits [15:0], `bus_addr` equal to the address and both strobes high. In every other cycle `bus_addr` is 0. The strobe is low for 1+W cycles and `busy` lasts 2+W cycles.
- R4: Once boot is over, the internal wait count for a request to region c is the plain binary value of `cfg_waits[2c+1:2c]` (0 to 3). Each internal wait adds exactly one cycle.
- R5: READY is looked at only after the internal waits have run out. Each cycle in which it is low in the final strobe state adds one cycle. A low READY during the address state or the internal waits has no effect.
- R6: The first completed cycle after reset uses exactly three internal waits, whatever `cfg_waits` holds.
- R7: The second completed cycle after reset uses, as its internal wait count, bits [5:4] of `bus_ad_in` as sampled in the final state of the first cycle.
- R8: For a read, `rsp_rdata` holds the value of `bus_ad_in` from the final strobe state. It is returned with a `rsp_valid` pulse one cycle long, in the cycle after that state. For a write, `rsp_valid` is also pulsed.
- R9: During the strobe of a write, `bus_ad_oe` is high and `bus_ad_out` equals the write data. During the strobe of a read, `bus_ad_oe` is low.
- R10: During a busy cycle only the chip select `bus_cs_n[req_cs]` is low, and `bus_rd_n` and `bus_wr_n` are never both low. A strobe is low only for the requested direction.
- R11: After reset: `busy` = 0, `req_ready` = 1, `rsp_valid` = 0, both strobes high, all chip selects high, `bus_ale` = 0 and `bus_ad_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select region index |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured in the final state |
| busy | output | 1 | A bus cycle is in progress |
| cfg_waits | input | 8 | 2-bit internal wait count per region |
| cfg_muxed | input | 4 | Multiplexed-mode flag per region |
| bus_addr | output | 20 | Address lines |
| bus_ad_out | output | 16 | AD lines, outgoing value |
| bus_ad_oe | output | 1 | AD output enable |
| bus_ad_in | input | 16 | AD lines, incoming value |
| bus_ale | output | 1 | Address state of a multiplexed cycle |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_ready | input | 1 | Device ready; low requests extra states |

## Verification
The bench uses the default parameters: 20 address bits, 16 data bits and four regions. The regions are set to wait counts 0 to 3, with regions 0 and 2 multiplexed. This puts every wait value in both bus modes within reach in a few transactions. The first read returns 01 in bits [5:4], so the second cycle must use one internal wait while its region is set to three, which makes the boot override visible at the ports. READY is held low for a chosen number of strobe states per transaction. Some counts end inside the internal waits and must add nothing; others reach past them and must extend the final state cycle for cycle.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_LEAD = 3'd2,
    ST_WAIT = 3'd3,
    ST_LAST = 3'd4
  } xbus_state_e;
endpackage

// File: rtl/xbus_waitsel.sv
`timescale 1ns/1ps
// Chooses the internal wait count for the next cycle: fixed boot count,
// then the field seen during the first cycle, then the per-region setting.
module xbus_waitsel #(
  parameter int CS_N        = 4,
  parameter int CS_W        = 2,
  parameter int WS_W        = 2,
  parameter int BOOT_WAITS  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CS_W-1:0]      cs,
  input  logic [CS_N*WS_W-1:0] cfg_waits,
  input  logic                 done,
  input  logic [WS_W-1:0]      boot_field,
  output logic [WS_W-1:0]      waits
);
  localparam logic [1:0] PH_FIRST  = 2'd0;
  localparam logic [1:0] PH_SECOND = 2'd1;
  localparam logic [1:0] PH_NORMAL = 2'd2;

  logic [1:0]      phase;
  logic [WS_W-1:0] boot_ws;
  logic [WS_W-1:0] region_ws [CS_N];

  for (genvar g = 0; g < CS_N; g++) begin : g_unpack
    assign region_ws[g] = cfg_waits[g*WS_W +: WS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_FIRST;
      boot_ws <= '0;
    end else if (done) begin
      if (phase == PH_FIRST) boot_ws <= boot_field;
      if (phase != PH_NORMAL) phase <= phase + 2'd1;
    end
  end

  always_comb begin
    case (phase)
      PH_FIRST:  waits = WS_W'(BOOT_WAITS);
      PH_SECOND: waits = boot_ws;
      default:   waits = region_ws[cs];
    endcase
  end
endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
// Bus-state sequencer: address state, optional lead strobe state,
// internal waits, then a final state extended while READY is low.
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            muxed,
  input  logic [WS_W-1:0] waits,
  input  logic            ready,
  output xbus_state_e     state,
  output logic            done
);
  logic [WS_W-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ADDR;
          wcnt  <= waits;
        end
        ST_ADDR: begin
          if (!muxed)          state <= ST_LEAD;
          else if (wcnt != '0) state <= ST_WAIT;
          else                 state <= ST_LAST;
        end
        ST_LEAD: state <= (wcnt != '0) ? ST_WAIT : ST_LAST;
        ST_WAIT: begin
          wcnt <= wcnt - 1'b1;
          if (wcnt == WS_W'(1)) state <= ST_LAST;
        end
        ST_LAST: if (ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_LAST) && ready;
endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
// Decodes the sequencer state and the latched request into bus pins.
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CS_N   = 4,
  parameter int CS_W   = 2
) (
  input  xbus_state_e       state,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              write,
  input  logic [CS_W-1:0]   cs,
  input  logic              muxed,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [CS_N-1:0]   bus_cs_n
);
  logic active, strobe, addr_st;

  assign active  = (state != ST_IDLE);
  assign addr_st = (state == ST_ADDR);
  assign strobe  = (state == ST_LEAD) || (state == ST_WAIT) || (state == ST_LAST);

  assign bus_rd_n = !(strobe && !write);
  assign bus_wr_n = !(strobe && write);
  assign bus_ale  = muxed && addr_st;

  always_comb begin
    if (muxed) bus_addr = addr_st ? addr : '0;
    else       bus_addr = active  ? addr : '0;
  end

  always_comb begin
    bus_ad_oe  = 1'b0;
    bus_ad_out = '0;
    if (bus_ale) begin
      bus_ad_oe  = 1'b1;
      bus_ad_out = addr[DATA_W-1:0];
    end else if (strobe && write) begin
      bus_ad_oe  = 1'b1;
      bus_ad_out = wdata;
    end
  end

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign bus_cs_n[g] = !(active && (cs == CS_W'(g)));
  end
endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CS_N        = 4,
  parameter int WS_W        = 2,
  parameter int BOOT_WAITS  = 3,
  parameter int BOOT_WS_LSB = 4,
  localparam int CS_W       = (CS_N > 1) ? $clog2(CS_N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 req_write,
  input  logic [CS_W-1:0]      req_cs,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 busy,
  input  logic [CS_N*WS_W-1:0] cfg_waits,
  input  logic [CS_N-1:0]      cfg_muxed,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_ad_out,
  output logic                 bus_ad_oe,
  input  logic [DATA_W-1:0]    bus_ad_in,
  output logic                 bus_ale,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [CS_N-1:0]      bus_cs_n,
  input  logic                 bus_ready
);
  xbus_state_e       state;
  logic              accept, done;
  logic [WS_W-1:0]   waits;
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata;
  logic              a_write, a_mux;
  logic [CS_W-1:0]   a_cs;

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr  <= '0;
      a_wdata <= '0;
      a_write <= 1'b0;
      a_mux   <= 1'b0;
      a_cs    <= '0;
    end else if (accept) begin
      a_addr  <= req_addr;
      a_wdata <= req_wdata;
      a_write <= req_write;
      a_mux   <= cfg_muxed[req_cs];
      a_cs    <= req_cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done;
      if (done && !a_write) rsp_rdata <= bus_ad_in;
    end
  end

  xbus_waitsel #(
    .CS_N(CS_N), .CS_W(CS_W), .WS_W(WS_W), .BOOT_WAITS(BOOT_WAITS)
  ) u_waitsel (
    .clk(clk), .rst_n(rst_n), .cs(req_cs), .cfg_waits(cfg_waits),
    .done(done), .boot_field(bus_ad_in[BOOT_WS_LSB +: WS_W]), .waits(waits)
  );

  xbus_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .muxed(a_mux),
    .waits(waits), .ready(bus_ready), .state(state), .done(done)
  );

  xbus_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .CS_W(CS_W)
  ) u_pins (
    .state(state), .addr(a_addr), .wdata(a_wdata), .write(a_write),
    .cs(a_cs), .muxed(a_mux), .bus_addr(bus_addr), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
`timescale 1ns/1ps
module xbus_ctrl_chk #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            busy,
  input logic            rsp_valid,
  input logic            bus_rd_n,
  input logic            bus_wr_n,
  input logic [CS_N-1:0] bus_cs_n,
  input logic            bus_ale,
  input logic            bus_ready
);
  logic strobe;
  assign strobe = !bus_rd_n || !bus_wr_n;

  p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  p_single_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~bus_cs_n) == 1);

  p_no_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_ready_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !bus_ready) |=> strobe);

  p_rsp_follows_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(strobe) && !strobe);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ale_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && busy));

  p_cs_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_cs_n));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.CS_N(CS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_ready(bus_ready)
);

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cs = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic [7:0]  cfg_waits = 8'b11_10_01_00;
  logic [3:0]  cfg_muxed = 4'b0101;
  logic [19:0] bus_addr;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic        bus_ale;
  logic        bus_rd_n, bus_wr_n;
  logic [3:0]  bus_cs_n;
  logic        bus_ready = 1'b1;

  always #4 clk = ~clk;

  xbus_ctrl uut (.*);

  typedef struct {
    int          str;
    int          tot;
    logic [15:0] data;
    bit          rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, done_cnt = 0, sent = 0;
  logic [1:0] boot_ws_exp = 2'd0;

  logic [19:0] cur_addr = '0;
  logic [15:0] cur_wdata = '0;
  logic        cur_wr = 1'b0, cur_mux = 1'b0;
  logic [1:0]  cur_cs = '0;
  int          cur_j = 0;

  int  busy_cnt = 0, str_cnt = 0, sidx = 0;
  bit  pin_bad = 0, prev_rsp = 0;

  function automatic logic [15:0] mem(input logic [19:0] a);
    return a[15:0] ^ 16'h5A00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: issues a request and pushes the expected outcome.
  task automatic send(input logic [19:0] a, input logic [15:0] d, input bit wr,
                      input logic [1:0] cs, input int j, input string tag);
    int k, lead, ex;
    exp_t e;
    while (done_cnt != sent) @(negedge clk);
    @(negedge clk);
    #1;
    if (sent == 0)      k = 3;
    else if (sent == 1) k = int'(boot_ws_exp);
    else                k = int'(cfg_waits[cs*2 +: 2]);
    lead = cfg_muxed[cs] ? 0 : 1;
    ex = j - lead - k;
    if (ex < 0) ex = 0;
    e.str = lead + 1 + k + ex;
    e.tot = e.str + 1;
    e.data = mem(a);
    e.rd = !wr;
    e.tag = tag;
    if (sent == 0) boot_ws_exp = mem(a)[5:4];
    q.push_back(e);
    cur_addr = a; cur_wdata = d; cur_wr = wr; cur_cs = cs; cur_j = j;
    cur_mux = cfg_muxed[cs];
    req_addr = a; req_wdata = d; req_write = wr; req_cs = cs;
    req_valid = 1'b1;
    sent++;
    @(negedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Monitor and device model.
  always @(negedge clk) begin
    if (rst_n) begin
      bit s;
      s = !bus_rd_n || !bus_wr_n;
      bus_ad_in = mem(cur_addr);
      if (busy) begin
        if (req_ready) pin_bad = 1;
        if (bus_cs_n != ~(4'b0001 << cur_cs)) pin_bad = 1;
        if (cur_mux) begin
          if (busy_cnt == 0) begin
            if (!bus_ale || !bus_ad_oe || bus_ad_out != cur_addr[15:0] ||
                bus_addr != cur_addr || s) pin_bad = 1;
          end else if (bus_ale || bus_addr != '0) pin_bad = 1;
        end else if (bus_addr != cur_addr || bus_ale) pin_bad = 1;
        if (s) begin
          if (cur_wr && (!bus_rd_n || !bus_ad_oe || bus_ad_out != cur_wdata)) pin_bad = 1;
          if (!cur_wr && (!bus_wr_n || bus_ad_oe)) pin_bad = 1;
        end
        busy_cnt++;
      end
      if (s) begin
        bus_ready = (sidx < cur_j) ? 1'b0 : 1'b1;
        sidx++;
        str_cnt++;
      end else bus_ready = 1'b1;
      if (rsp_valid) begin
        exp_t e;
        check(!prev_rsp, "R8 pulse", 1, 0);
        if (q.size() == 0) check(0, "R8 unexpected response", 1, 0);
        else begin
          e = q.pop_front();
          check(str_cnt == e.str, {e.tag, " strobe length"}, str_cnt, e.str);
          check(busy_cnt == e.tot, {"R1 busy length ", e.tag}, busy_cnt, e.tot);
          check(!pin_bad, {"R3 R9 R10 pins ", e.tag}, int'(pin_bad), 0);
          if (e.rd) check(rsp_rdata == e.data, {"R8 read data ", e.tag}, rsp_rdata, e.data);
        end
        busy_cnt = 0; str_cnt = 0; sidx = 0; pin_bad = 0;
        done_cnt++;
      end
      prev_rsp = rsp_valid;
    end
  end

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d responses", done_cnt, sent);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && req_ready && !rsp_valid, "R11 idle flags", {busy, req_ready, rsp_valid}, 3'b010);
    check(bus_rd_n && bus_wr_n && bus_cs_n == 4'hF, "R11 strobes",
          {bus_rd_n, bus_wr_n, bus_cs_n}, 6'h3F);
    check(!bus_ale && !bus_ad_oe, "R11 AD idle", {bus_ale, bus_ad_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(20'h00010, 16'h0, 0, 2'd1, 0, "R6 boot first demux");
    send(20'h12345, 16'h0, 0, 2'd3, 0, "R7 boot second");
    send(20'h0ABCD, 16'h0, 0, 2'd0, 0, "R3 mux read k0");
    send(20'h00F0F, 16'hBEEF, 1, 2'd2, 0, "R9 R4 mux write k2");
    send(20'h3C3C3, 16'h1357, 1, 2'd3, 2, "R5 ready low in waits ignored");
    send(20'h01111, 16'h0, 0, 2'd0, 3, "R5 mux ready extends");
    send(20'h52222, 16'h0, 0, 2'd1, 5, "R2 R5 demux ready extends");
    send(20'h0F0F0, 16'h0, 0, 2'd2, 4, "R4 R5 mux k2 ready");
    send(20'hFFFFF, 16'hA5A5, 1, 2'd1, 0, "R2 demux write k1");
    while (done_cnt != sent) @(negedge clk);
    @(negedge clk);
    check(q.size() == 0, "R1 all responses seen", q.size(), 0);
    check(!busy && req_ready, "R1 idle after run", {busy, req_ready}, 2'b01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule